// File: doc/BRIEF.md
# Multi-Mode Iterative Divider

A sequential divider that produces a 16-bit quotient and a 16-bit remainder from a 32-bit dividend and a 16-bit divisor. One engine covers five operations: unsigned and signed division of a full 32-bit dividend, unsigned and signed division of a 16-bit dividend, and a signed Q15 fractional division. Short dividends are widened to 32 bits when the operands are captured, and fractional dividends are scaled by 2^15. The engine therefore always runs the same number of steps and has one fixed latency for every mode.

Operands are captured on the clock edge that samples the start strobe. The core then runs eighteen non-restoring steps on magnitudes, one step per clock. It then fixes the signs and checks the range, and raises a one-cycle done strobe together with the quotient, the remainder and two flags: overflow and divide-by-zero. All partial state sits in registers, so a hold input can freeze the engine between any two steps and release it later without losing work. The outputs keep their last values until the next operation completes.

Top module: `iter_divider`

## Requirements
- R1: Mode code 0 (and the unused codes 5, 6, 7) divides dividend[15:0] by the divisor as unsigned numbers. Code 2 divides the whole 32-bit dividend by the divisor as unsigned numbers. The quotient is the floor and the remainder is what is left.
- R2: Code 1 divides dividend[15:0] and code 3 divides the full dividend, both in two's complement. The quotient truncates toward zero and a nonzero remainder has the sign of the dividend.
- R3: Code 4 treats dividend[15:0] and the divisor as signed Q15 values. The result is the signed quotient of (dividend[15:0] * 2^15) / divisor, truncated toward zero, with the remainder of that division.
- R4: In codes 0 and 1, dividend[31:16] has no effect on any output.
- R5: When start_i is sampled at rising edge k while the block is idle, done_o is high for exactly one cycle, just after edge k+18 (if no hold occurs). The results are valid from that edge and stay unchanged until the next completion.
- R6: While an operation is in progress, every rising edge at which hold_i is high freezes the engine and delays done_o by one cycle. The results are unchanged by the pause.
- R7: start_i and new operand values presented while an operation is in progress are ignored. They do not change its results or its latency.
- R8: A zero divisor sets dbz_o, clears ovf_o, drives quot_o to 16'hFFFF and returns dividend[15:0] on rem_o.
- R9: ovf_o is raised when the divisor is nonzero and the true quotient falls outside the quotient range of the mode (0..65535 unsigned; -32768..32767 signed and fractional). quot_o and rem_o are unspecified in that case.
- R10: After reset, quot_o, rem_o, done_o, ovf_o and dbz_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled only while idle |
| hold_i | input | 1 | Freezes an operation in progress |
| mode_i | input | 3 | Operation code (see R1 to R3) |
| dividend_i | input | 32 | Dividend; only bits 15:0 are used for codes 0, 1, 4 |
| divisor_i | input | 16 | Divisor |
| quot_o | output | 16 | Quotient |
| rem_o | output | 16 | Remainder |
| done_o | output | 1 | One-cycle completion strobe |
| ovf_o | output | 1 | Quotient out of range |
| dbz_o | output | 1 | Divisor was zero |

## Verification
The bench targets the range boundaries in each signed mode. A quotient of exactly -32768 must pass, and +32768 must flag. Examples are -98304/3 against 98304/3, fractional -0.5/0.5 against 0.5/0.5, and the most negative dividend divided by -1. A design that checked the range on magnitude alone, or one that saturated too early, would flag the first of each pair or miss the second. It also divides negative dividends with small remainders: a remainder given the sign of the divisor, or a quotient floored instead of truncated, fails there. Garbage in the upper dividend word of the 16-bit modes exposes missing extension. Holds and start pulses in the middle of an operation, with operands changed behind them, expose state that is not really frozen and operands that are captured again.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

    typedef enum logic [2:0] {
        MD_U16  = 3'd0,
        MD_S16  = 3'd1,
        MD_U32  = 3'd2,
        MD_S32  = 3'd3,
        MD_FRAC = 3'd4
    } div_mode_e;

    typedef struct packed {
        logic is_signed;
        logic is_long;
        logic is_frac;
    } mode_info_t;

    function automatic mode_info_t decode_mode(logic [2:0] code);
        mode_info_t info;
        info = '0;
        case (code)
            MD_S16:  info.is_signed = 1'b1;
            MD_U32:  info.is_long   = 1'b1;
            MD_S32:  begin info.is_signed = 1'b1; info.is_long = 1'b1; end
            MD_FRAC: begin info.is_signed = 1'b1; info.is_frac = 1'b1; end
            default: info = '0;
        endcase
        return info;
    endfunction

endpackage

// File: rtl/idiv_prep.sv
// Operand conditioning: widening, fractional scaling and magnitude extraction.
module idiv_prep
    import idiv_pkg::*;
#(
    parameter int DW = 16
) (
    input  mode_info_t          info_i,
    input  logic [2*DW-1:0]     dividend_i,
    input  logic [DW-1:0]       divisor_i,
    output logic [2*DW-1:0]     dmag_o,
    output logic [DW-1:0]       vmag_o,
    output logic                dneg_o,
    output logic                vneg_o
);
    localparam int DDW = 2 * DW;

    logic [DDW-1:0] ext;

    always_comb begin
        if (info_i.is_frac) begin
            ext = {dividend_i[DW-1], dividend_i[DW-1:0], {(DW-1){1'b0}}};
        end else if (info_i.is_long) begin
            ext = dividend_i;
        end else if (info_i.is_signed) begin
            ext = {{DW{dividend_i[DW-1]}}, dividend_i[DW-1:0]};
        end else begin
            ext = {{DW{1'b0}}, dividend_i[DW-1:0]};
        end
        dneg_o = info_i.is_signed & ext[DDW-1];
        vneg_o = info_i.is_signed & divisor_i[DW-1];
        dmag_o = dneg_o ? (~ext + DDW'(1)) : ext;
        vmag_o = vneg_o ? (~divisor_i + DW'(1)) : divisor_i;
    end
endmodule

// File: rtl/idiv_step.sv
// One non-restoring step on a two's complement partial remainder.
module idiv_step #(
    parameter int DW = 16,
    parameter int RW = DW + 3
) (
    input  logic [RW-1:0] r_i,
    input  logic [DW-1:0] v_i,
    input  logic          bit_i,
    output logic [RW-1:0] r_o,
    output logic          q_o
);
    logic [RW-1:0] shifted;
    logic [RW-1:0] vx;

    always_comb begin
        shifted = {r_i[RW-2:0], bit_i};
        vx      = {{(RW-DW){1'b0}}, v_i};
        r_o     = r_i[RW-1] ? (shifted + vx) : (shifted - vx);
        q_o     = ~r_o[RW-1];
    end
endmodule

// File: rtl/idiv_post.sv
// Final remainder correction, sign restoration, range check and zero-divisor override.
module idiv_post #(
    parameter int DW = 16,
    parameter int QW = DW + 2,
    parameter int RW = DW + 3
) (
    input  logic [RW-1:0] r_fin_i,
    input  logic [QW-1:0] qmag_i,
    input  logic [DW-1:0] vmag_i,
    input  logic          sgn_i,
    input  logic          dneg_i,
    input  logic          vneg_i,
    input  logic          pre_ov_i,
    input  logic          dz_i,
    input  logic [DW-1:0] dlow_i,
    output logic [DW-1:0] quot_o,
    output logic [DW-1:0] rem_o,
    output logic          ov_o,
    output logic          dbz_o
);
    localparam logic [QW-1:0] HALF = QW'(1) << (DW - 1);

    logic [DW-1:0] rmag;
    logic          qneg;

    always_comb begin
        rmag = r_fin_i[RW-1] ? DW'(r_fin_i + {{(RW-DW){1'b0}}, vmag_i}) : r_fin_i[DW-1:0];
        qneg = sgn_i & (dneg_i ^ vneg_i);
        if (!sgn_i) begin
            ov_o = pre_ov_i | (|qmag_i[QW-1:DW]);
        end else if (qneg) begin
            ov_o = pre_ov_i | (qmag_i > HALF);
        end else begin
            ov_o = pre_ov_i | (qmag_i >= HALF);
        end
        quot_o = qneg ? (~qmag_i[DW-1:0] + DW'(1)) : qmag_i[DW-1:0];
        rem_o  = dneg_i ? (~rmag + DW'(1)) : rmag;
        dbz_o  = 1'b0;
        if (dz_i) begin
            quot_o = '1;
            rem_o  = dlow_i;
            ov_o   = 1'b0;
            dbz_o  = 1'b1;
        end
    end
endmodule

// File: rtl/iter_divider.sv
module iter_divider
    import idiv_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            hold_i,
    input  logic [2:0]      mode_i,
    input  logic [2*DW-1:0] dividend_i,
    input  logic [DW-1:0]   divisor_i,
    output logic [DW-1:0]   quot_o,
    output logic [DW-1:0]   rem_o,
    output logic            done_o,
    output logic            ovf_o,
    output logic            dbz_o
);
    localparam int DDW  = 2 * DW;
    localparam int ITER = DW + 2;
    localparam int CW   = $clog2(ITER + 1);
    localparam int RW   = DW + 3;

    typedef struct packed {
        logic            busy;
        logic [CW-1:0]   cnt;
        logic [RW-1:0]   racc;
        logic [ITER-1:0] qsh;
        logic [DW-1:0]   vmag;
        logic            sgn;
        logic            dneg;
        logic            vneg;
        logic            pre_ov;
        logic            dz;
        logic [DW-1:0]   dlow;
        logic [DW-1:0]   quot;
        logic [DW-1:0]   rem;
        logic            done;
        logic            ov;
        logic            dbz;
    } st_t;

    st_t st_d, st_q;

    mode_info_t      info;
    logic [DDW-1:0]  dmag;
    logic [DW-1:0]   vmag;
    logic            dneg, vneg;
    logic [RW-1:0]   r_nxt;
    logic            q_bit;
    logic [ITER-1:0] qmag;
    logic [DW-1:0]   p_quot, p_rem;
    logic            p_ov, p_dbz;

    assign info = decode_mode(mode_i);
    assign qmag = {st_q.qsh[ITER-2:0], q_bit};

    idiv_prep #(.DW(DW)) u_prep (
        .info_i     (info),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .dmag_o     (dmag),
        .vmag_o     (vmag),
        .dneg_o     (dneg),
        .vneg_o     (vneg)
    );

    idiv_step #(.DW(DW), .RW(RW)) u_step (
        .r_i   (st_q.racc),
        .v_i   (st_q.vmag),
        .bit_i (st_q.qsh[ITER-1]),
        .r_o   (r_nxt),
        .q_o   (q_bit)
    );

    idiv_post #(.DW(DW), .QW(ITER), .RW(RW)) u_post (
        .r_fin_i  (r_nxt),
        .qmag_i   (qmag),
        .vmag_i   (st_q.vmag),
        .sgn_i    (st_q.sgn),
        .dneg_i   (st_q.dneg),
        .vneg_i   (st_q.vneg),
        .pre_ov_i (st_q.pre_ov),
        .dz_i     (st_q.dz),
        .dlow_i   (st_q.dlow),
        .quot_o   (p_quot),
        .rem_o    (p_rem),
        .ov_o     (p_ov),
        .dbz_o    (p_dbz)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy   = 1'b1;
                st_d.cnt    = CW'(ITER);
                st_d.racc   = RW'(dmag >> ITER);
                st_d.qsh    = dmag[ITER-1:0];
                st_d.vmag   = vmag;
                st_d.sgn    = info.is_signed;
                st_d.dneg   = dneg;
                st_d.vneg   = vneg;
                st_d.pre_ov = (dmag >> ITER) >= DDW'(vmag);
                st_d.dz     = (divisor_i == '0);
                st_d.dlow   = dividend_i[DW-1:0];
            end
        end else if (!hold_i) begin
            st_d.racc = r_nxt;
            st_d.qsh  = qmag;
            st_d.cnt  = st_q.cnt - CW'(1);
            if (st_q.cnt == CW'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.quot = p_quot;
                st_d.rem  = p_rem;
                st_d.ov   = p_ov;
                st_d.dbz  = p_dbz;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign quot_o = st_q.quot;
    assign rem_o  = st_q.rem;
    assign done_o = st_q.done;
    assign ovf_o  = st_q.ov;
    assign dbz_o  = st_q.dbz;

    // Latency tracker for the checks below: counts unheld edges since capture.
    logic [CW-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (!st_q.busy && start_i) begin
            lat_q <= '0;
        end else if (st_q.busy && !hold_i) begin
            lat_q <= lat_q + CW'(1);
        end
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_q == CW'(ITER)));

    // R6
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && hold_i) |=> !done_o);

    // R7
    start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> $stable(st_q.vmag) && $stable(st_q.dlow));

    // R8
    dbz_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbz_o |-> (quot_o == '1) && !ovf_o);

endmodule

// File: tb/iter_divider_tb.sv
module iter_divider_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        hold_i = 1'b0;
    logic [2:0]  mode_i = 3'd0;
    logic [31:0] dividend_i = '0;
    logic [15:0] divisor_i = '0;
    logic [15:0] quot_o, rem_o;
    logic        done_o, ovf_o, dbz_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    iter_divider u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .hold_i     (hold_i),
        .mode_i     (mode_i),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .quot_o     (quot_o),
        .rem_o      (rem_o),
        .done_o     (done_o),
        .ovf_o      (ovf_o),
        .dbz_o      (dbz_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic void ref_div(input logic [2:0] md, input logic [31:0] a,
                                    input logic [15:0] b, output logic [15:0] eq,
                                    output logic [15:0] er, output bit eov, output bit edz);
        longint n, d, q, r;
        bit sgn;
        sgn = (md == 3'd1) || (md == 3'd3) || (md == 3'd4);
        case (md)
            3'd1:    n = $signed(a[15:0]);
            3'd2:    n = {32'b0, a};
            3'd3:    n = $signed(a);
            3'd4:    n = longint'($signed(a[15:0])) * 32768;
            default: n = {48'b0, a[15:0]};
        endcase
        if (sgn) d = $signed(b);
        else     d = {48'b0, b};
        edz = (b == 16'h0);
        eov = 1'b0;
        if (edz) begin
            eq = 16'hFFFF;
            er = a[15:0];
        end else begin
            q = n / d;
            r = n % d;
            eq = q[15:0];
            er = r[15:0];
            if (sgn) eov = (q > 32767) || (q < -32768);
            else     eov = (q > 65535);
        end
    endfunction

    function automatic string mode_tag(input logic [2:0] md);
        case (md)
            3'd1, 3'd3: return "R2";
            3'd4:       return "R3";
            default:    return "R1";
        endcase
    endfunction

    // Runs one division; hold_n held edges; poke drives start and new operands mid-run.
    task automatic do_op(input logic [2:0] md, input logic [31:0] a, input logic [15:0] b,
                         input int hold_n, input bit poke, input string tag_in);
        logic [15:0] eq, er;
        bit eov, edz;
        int lat, held;
        string tag;
        ref_div(md, a, b, eq, er, eov, edz);
        tag = (tag_in != "") ? tag_in : (edz ? "R8" : (eov ? "R9" : mode_tag(md)));
        @(negedge clk);
        mode_i = md; dividend_i = a; divisor_i = b; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = poke;
        mode_i = 3'($urandom);
        dividend_i = $urandom;
        divisor_i = 16'($urandom);
        hold_i = (hold_n > 0);
        lat = 1;
        held = 0;
        while (!done_o && lat < 80) begin
            @(negedge clk);
            lat++;
            if (lat == 3) start_i = 1'b0;
            if (hold_i) begin
                held++;
                if (held >= hold_n) hold_i = 1'b0;
            end
        end
        start_i = 1'b0;
        hold_i = 1'b0;
        check(lat == 19 + hold_n, hold_n > 0 ? "R6" : (poke ? "R7" : "R5"),
              "latency", lat, 19 + hold_n);
        if (eov) begin
            check(ovf_o == 1'b1 && dbz_o == 1'b0, tag, "ovf flag", ovf_o, 1);
        end else begin
            check(quot_o == eq, tag, "quotient", quot_o, eq);
            check(rem_o == er, tag, "remainder", rem_o, er);
            check(ovf_o == 1'b0, tag, "ovf flag", ovf_o, 0);
            check(dbz_o == edz, tag, "dbz flag", dbz_o, edz);
        end
        @(negedge clk);
        check(done_o == 1'b0, "R5", "done width", done_o, 0);
        check(quot_o == (eov ? quot_o : eq), "R5", "quotient held", quot_o, eq);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] ra;
        logic [15:0] rb;
        logic [2:0]  rm;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check(quot_o == 0 && rem_o == 0, "R10", "results in reset", {quot_o, rem_o}, 0);
        check(!done_o && !ovf_o && !dbz_o, "R10", "flags in reset", {done_o, ovf_o, dbz_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done_o && quot_o == 0 && rem_o == 0, "R10", "idle after reset",
              {done_o, quot_o, rem_o}, 0);

        // R1: unsigned directed
        do_op(3'd0, 32'h0000_FFFF, 16'h0001, 0, 0, "R1");
        do_op(3'd0, 32'h0000_1234, 16'h00FF, 0, 0, "R1");
        do_op(3'd6, 32'hABCD_8001, 16'h0007, 0, 0, "R1");
        do_op(3'd2, 32'hFFFE_0001, 16'hFFFF, 0, 0, "R1");
        do_op(3'd2, 32'h0001_0000, 16'h0001, 0, 0, "R9");
        // R2: signed truncation and remainder sign
        do_op(3'd1, 32'h0000_FFF9, 16'h0002, 0, 0, "R2");
        do_op(3'd1, 32'h0000_0007, 16'hFFFE, 0, 0, "R2");
        do_op(3'd3, -32'sd1000001, 16'd1000, 0, 0, "R2");
        do_op(3'd3, -32'sd98304, 16'd3, 0, 0, "R2");
        do_op(3'd3, 32'd98304, 16'd3, 0, 0, "R9");
        do_op(3'd3, 32'h8000_0000, 16'hFFFF, 0, 0, "R9");
        do_op(3'd1, 32'h0000_8000, 16'hFFFF, 0, 0, "R9");
        // R3: fractional
        do_op(3'd4, 32'h0000_2000, 16'h4000, 0, 0, "R3");
        do_op(3'd4, 32'h0000_C000, 16'h4000, 0, 0, "R3");
        do_op(3'd4, 32'h0000_4000, 16'hC000, 0, 0, "R3");
        do_op(3'd4, 32'h0000_4000, 16'h7FFF, 0, 0, "R3");
        do_op(3'd4, 32'h0000_4000, 16'h4000, 0, 0, "R9");
        do_op(3'd4, 32'h0000_8000, 16'h8000, 0, 0, "R9");
        // R4: upper word ignored in 16/16 modes
        do_op(3'd1, 32'hDEAD_0064, 16'h0007, 0, 0, "R4");
        do_op(3'd0, 32'hFFFF_0064, 16'h0007, 0, 0, "R4");
        do_op(3'd1, 32'h0000_FF9C, 16'h0007, 0, 0, "R4");
        // R8: zero divisor
        do_op(3'd3, 32'h1234_5678, 16'h0000, 0, 0, "R8");
        do_op(3'd4, 32'h0000_8000, 16'h0000, 0, 0, "R8");
        // R6 and R7: hold and ignored start
        do_op(3'd3, -32'sd77777, 16'd123, 5, 0, "R6");
        do_op(3'd2, 32'h0123_4567, 16'h1234, 1, 0, "R6");
        do_op(3'd1, 32'h0000_8001, 16'h0003, 0, 1, "R7");
        do_op(3'd4, 32'h0000_A000, 16'h6000, 3, 1, "R7");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            rm = 3'($urandom);
            ra = $urandom;
            rb = 16'($urandom);
            if ($urandom % 2 == 0) ra = ra >> ($urandom % 17);
            if ($urandom % 4 == 0) rb = rb >> ($urandom % 16);
            if ($urandom % 32 == 0) rb = 16'h0;
            do_op(rm, ra, rb, ($urandom % 6 == 0) ? int'($urandom % 4) : 0,
                  ($urandom % 8 == 0), "");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule